// File: doc/BRIEF.md
# Interrupt Status and Control Register Block

This block gathers single-cycle hardware event pulses into sticky status bits. It raises a level-held interrupt request whenever any latched event is enabled by its mask bit. Software reaches the block over a plain synchronous register bus with an address, a write strobe, write data and combinational read data. Software clears status bits one at a time by writing them. A build-time parameter chooses between write-one-to-clear and write-zero-to-clear.

An interrupt acknowledge input makes the block return a programmable vector, marked by a single-cycle valid strobe. A read-only register gives the firmware version. A self-clearing control bit resets every register to its power-up value without touching the external reset.

Top module: `irq_ctrl_regs`

## Requirements
- R1: A status bit becomes 1 only in the cycle after its `event_i` bit was 1. No bus write can set a status bit.
- R2: With the default `CLEAR_ON_ONE=1`, a write to offset 0x00 clears each status bit whose write-data bit is 1 and leaves the bits written 0 unchanged. With `CLEAR_ON_ONE=0`, the roles of 1 and 0 are swapped.
- R3: A read at any offset leaves every status bit unchanged, so two reads in a row return the same value.
- R4: Events are latched into status whatever the mask at offset 0x04 holds.
- R5: `irq_o` is 1 exactly when some bit is 1 in both status and mask. It stays 1 until software clears those bits or disables them in the mask.
- R6: If an event and a software clear hit the same status bit in the same cycle, the bit ends up 1.
- R7: The vector register sits at offset 0x08 in bits [VEC_W-1:0] and resets to 0x40. One cycle after `iack_i` rises, `ack_valid_o` is 1 for exactly one cycle and `ack_vector_o` carries the vector. The acknowledge clears no status bit.
- R8: Offset 0x0C reads the `VERSION` parameter (default 0x00010200), and writes to it are ignored.
- R9: Writing 1 to bit 0 of offset 0x10 sets that bit, and it reads back as 1 for one cycle. On the next clock edge, status, mask and vector return to their defaults: 0, 0 and 0x40.
- R10: Reserved bits of mapped registers and every unmapped offset read as 0. Writes to them have no visible effect.
- R11: After `rst_ni` is released, status and mask are 0, the vector is 0x40, and `irq_o` and `ack_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data for `addr_i` |
| event_i | input | NUM_EVENTS | Hardware event pulses |
| irq_o | output | 1 | Level interrupt request |
| iack_i | input | 1 | Interrupt acknowledge |
| ack_valid_o | output | 1 | One-cycle vector valid strobe |
| ack_vector_o | output | VEC_W | Returned interrupt vector |

## Verification
The bench sweeps every one of the 256 event patterns of the 8-bit configuration. Each pattern is paired with a computed mask pattern and a computed clear pattern. This separates a wrong interrupt reduction, a wrong clear polarity and status bits that interfere with each other. Separate directed patterns cover the remaining cases: an event and a clear landing on the same bit in one cycle, an acknowledge held for several cycles, and writes to reserved and unmapped offsets. The soft reset is triggered with every register holding a non-default value.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int unsigned OFS_STATUS  = 'h00;
  localparam int unsigned OFS_MASK    = 'h04;
  localparam int unsigned OFS_VECTOR  = 'h08;
  localparam int unsigned OFS_VERSION = 'h0C;
  localparam int unsigned OFS_CTRL    = 'h10;
  localparam int unsigned CTRL_SRST_BIT = 0;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_MASK, SEL_VECTOR, SEL_VERSION, SEL_CTRL
  } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N            = 8,
  parameter bit          CLEAR_ON_ONE = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [N-1:0] event_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] clr_req;

  generate
    if (CLEAR_ON_ONE) begin : g_w1c
      assign clr_req = {N{wr_i}} & wdata_i;
    end else begin : g_w0c
      assign clr_req = {N{wr_i}} & ~wdata_i;
    end
  endgenerate

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         status_o[i] <= 1'b0;
      else if (srst_i)     status_o[i] <= 1'b0;
      else if (event_i[i]) status_o[i] <= 1'b1;   // set beats clear
      else if (clr_req[i]) status_o[i] <= 1'b0;
    end
  end

  // R1
  no_sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & ~$past(status_o) & ~$past(event_i)) == '0));
  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(srst_i) |-> ((status_o & $past(event_i)) == $past(event_i)));
  // R3
  no_silent_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_i) && !$past(srst_i)) |-> ((~status_o & $past(status_o)) == '0));
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             iack_i,
  input  logic [VEC_W-1:0] vector_i,
  output logic             ack_valid_o,
  output logic [VEC_W-1:0] ack_vector_o
);
  logic iack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iack_q       <= 1'b0;
      ack_valid_o  <= 1'b0;
      ack_vector_o <= '0;
    end else if (srst_i) begin
      iack_q       <= iack_i;
      ack_valid_o  <= 1'b0;
      ack_vector_o <= '0;
    end else begin
      iack_q      <= iack_i;
      ack_valid_o <= iack_i & ~iack_q;
      if (iack_i & ~iack_q) ack_vector_o <= vector_i;
    end
  end

  // R7
  ack_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |=> !ack_valid_o);
  // R7
  ack_follows_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> ($past(iack_i) && !$past(srst_i)));
endmodule

// File: rtl/irq_soft_reset.sv
module irq_soft_reset (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic srst_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) srst_o <= 1'b0;
    else         srst_o <= trig_i & ~srst_o;
  end

  // R9
  srst_self_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> !srst_o);
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_regs_pkg::*;
#(
  parameter int unsigned NUM_EVENTS   = 8,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned ADDR_W       = 5,
  parameter int unsigned VEC_W        = 8,
  parameter bit          CLEAR_ON_ONE = 1'b1,
  parameter logic [31:0] VERSION      = 32'h0001_0200,
  parameter logic [7:0]  VEC_RESET    = 8'h40
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_en_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [DATA_W-1:0]     rd_data_o,
  input  logic [NUM_EVENTS-1:0] event_i,
  output logic                  irq_o,
  input  logic                  iack_i,
  output logic                  ack_valid_o,
  output logic [VEC_W-1:0]      ack_vector_o
);
  localparam logic [VEC_W-1:0] VEC_DEF = VEC_W'(VEC_RESET);

  reg_sel_e              sel;
  logic [NUM_EVENTS-1:0] status;
  logic [NUM_EVENTS-1:0] mask_q;
  logic [VEC_W-1:0]      vector_q;
  logic                  srst;
  logic                  srst_trig;

  always_comb begin
    unique case (32'(addr_i))
      OFS_STATUS:  sel = SEL_STATUS;
      OFS_MASK:    sel = SEL_MASK;
      OFS_VECTOR:  sel = SEL_VECTOR;
      OFS_VERSION: sel = SEL_VERSION;
      OFS_CTRL:    sel = SEL_CTRL;
      default:     sel = SEL_NONE;
    endcase
  end

  assign srst_trig = wr_en_i && (sel == SEL_CTRL) && wr_data_i[CTRL_SRST_BIT];

  irq_soft_reset u_srst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (srst_trig),
    .srst_o (srst)
  );

  irq_status_bank #(.N(NUM_EVENTS), .CLEAR_ON_ONE(CLEAR_ON_ONE)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (srst),
    .event_i  (event_i),
    .wr_i     (wr_en_i && (sel == SEL_STATUS)),
    .wdata_i  (wr_data_i[NUM_EVENTS-1:0]),
    .status_o (status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      vector_q <= VEC_DEF;
    end else if (srst) begin
      mask_q   <= '0;
      vector_q <= VEC_DEF;
    end else if (wr_en_i) begin
      if (sel == SEL_MASK)   mask_q   <= wr_data_i[NUM_EVENTS-1:0];
      if (sel == SEL_VECTOR) vector_q <= wr_data_i[VEC_W-1:0];
    end
  end

  assign irq_o = |(status & mask_q);

  irq_ack_unit #(.VEC_W(VEC_W)) u_ack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .srst_i       (srst),
    .iack_i       (iack_i),
    .vector_i     (vector_q),
    .ack_valid_o  (ack_valid_o),
    .ack_vector_o (ack_vector_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (sel)
      SEL_STATUS:  rd_data_o[NUM_EVENTS-1:0] = status;
      SEL_MASK:    rd_data_o[NUM_EVENTS-1:0] = mask_q;
      SEL_VECTOR:  rd_data_o[VEC_W-1:0]      = vector_q;
      SEL_VERSION: rd_data_o                 = DATA_W'(VERSION);
      SEL_CTRL:    rd_data_o[CTRL_SRST_BIT]  = srst;
      default:     rd_data_o                 = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^wr_data_i;

  // R9
  srst_defaults_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(srst) |-> (mask_q == '0 && vector_q == VEC_DEF && status == '0));
  // R5
  irq_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(irq_o) && !$past(wr_en_i) && !$past(srst)) |-> irq_o);
  // R4
  masked_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(event_i) != '0 && !$past(srst)) |-> (status != '0));
endmodule

// File: tb/irq_ctrl_regs_bench.sv
module irq_ctrl_regs_bench;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wen = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] ev = '0;
  logic        irq;
  logic        iack = 1'b0;
  logic        ack_valid;
  logic [7:0]  ack_vec;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  irq_ctrl_regs u_irq_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wen),
    .wr_data_i(wdata), .rd_data_o(rdata), .event_i(ev), .irq_o(irq),
    .iack_i(iack), .ack_valid_o(ack_valid), .ack_vector_o(ack_vec)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wen = 1'b1;
    @(negedge clk); wen = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic pulse(input logic [N-1:0] p);
    @(negedge clk); ev = p;
    @(negedge clk); ev = '0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] r, r2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    rd(5'h00, r); check("R11 status", r, 0);
    rd(5'h04, r); check("R11 mask", r, 0);
    rd(5'h08, r); check("R11 vector", r, 32'h40);
    check("R11 irq", {31'd0, irq}, 0);
    check("R11 ack_valid", {31'd0, ack_valid}, 0);
    // R8 version and read-only
    rd(5'h0C, r); check("R8 version", r, 32'h0001_0200);
    wr(5'h0C, 32'hDEAD_BEEF);
    rd(5'h0C, r); check("R8 write ignored", r, 32'h0001_0200);
    // R1 software write cannot set status (with either data polarity)
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, r); check("R1 write ones", r, 0);
    wr(5'h00, 32'h0); rd(5'h00, r); check("R1 write zeros", r, 0);

    // exhaustive sweep over event patterns
    for (int p = 0; p < 256; p++) begin
      logic [7:0] m, q, left;
      m = 8'((p * 37 + 11) & 255);
      q = 8'((p * 91 + 5) & 255);
      wr(5'h04, 32'h0);
      wr(5'h00, 32'hFF);
      pulse(8'(p));
      rd(5'h00, r); check("R4 latch masked", r, p);
      rd(5'h00, r2); check("R3 read no side effect", r2, p);
      wr(5'h04, {24'hFFFF_FF, m});
      rd(5'h04, r); check("R10 mask reserved", r, {24'd0, m});
      check("R5 irq level", {31'd0, irq}, {31'd0, |(8'(p) & m)});
      wr(5'h00, {24'd0, q});
      left = 8'(p) & ~q;
      rd(5'h00, r); check("R2 clear on one", r, {24'd0, left});
      check("R5 irq after clear", {31'd0, irq}, {31'd0, |(left & m)});
    end

    // R5 irq held with no bus activity
    wr(5'h04, 32'h01); wr(5'h00, 32'hFF); pulse(8'h01);
    repeat (5) @(negedge clk);
    check("R5 irq held", {31'd0, irq}, 1);
    wr(5'h04, 32'h00);
    check("R5 irq drops on mask", {31'd0, irq}, 0);

    // R6 same-cycle set and clear
    wr(5'h00, 32'hFF);
    @(negedge clk); addr = 5'h00; wdata = 32'h03; wen = 1'b1; ev = 8'h01;
    @(negedge clk); wen = 1'b0; ev = '0;
    rd(5'h00, r); check("R6 set wins", r, 32'h01);

    // R7 vector and acknowledge
    wr(5'h08, 32'hFFFF_FFAB);
    rd(5'h08, r); check("R10 vector reserved", r, 32'hAB);
    pulse(8'h80);
    @(negedge clk); iack = 1'b1;
    @(negedge clk);
    check("R7 ack valid", {31'd0, ack_valid}, 1);
    check("R7 ack vector", {24'd0, ack_vec}, 32'hAB);
    @(negedge clk);
    check("R7 ack one cycle", {31'd0, ack_valid}, 0);
    @(negedge clk); iack = 1'b0;
    check("R7 held iack no repeat", {31'd0, ack_valid}, 0);
    rd(5'h00, r); check("R7 ack keeps status", r, 32'h81);

    // R10 unmapped offsets
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, r); check("R10 unmapped 0x14", r, 0);
    rd(5'h1C, r); check("R10 unmapped 0x1C", r, 0);
    rd(5'h02, r); check("R10 unaligned", r, 0);
    rd(5'h00, r); check("R10 unmapped write harmless", r, 32'h81);

    // R9 soft reset
    wr(5'h04, 32'hFF);
    check("R9 pre irq", {31'd0, irq}, 1);
    wr(5'h10, 32'h1);
    rd(5'h10, r); check("R9 ctrl bit pending", r, 1);
    @(negedge clk);
    rd(5'h10, r); check("R9 ctrl self clear", r, 0);
    rd(5'h00, r); check("R9 status default", r, 0);
    rd(5'h04, r); check("R9 mask default", r, 0);
    rd(5'h08, r); check("R9 vector default", r, 32'h40);
    check("R9 irq low", {31'd0, irq}, 0);
    wr(5'h10, 32'h0);
    rd(5'h04, r); check("R9 write zero no reset", r, 0);

    finish_run();
  end
endmodule